// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer with a small register bus. A 12-bit down-counter advances on a prescaled slow tick. Software controls it only through magic values written to a key register. One key lifts write protection, one starts the counter for good, and one reloads the counter so a healthy program can keep the watchdog away from zero. If the counter runs out, the block pulses a system reset request and then begins another period.

The prescaler, reload value and early-warning control are accepted only after the unlock key. Each accepted write is first held in a visible shadow copy. It moves into the counting side after three slow ticks, and a status flag stays busy until then. The slow clock is modelled as a one-cycle enable, `slow_tick`, in the bus clock domain. An early-warning flag is set when the counter passes a programmed compare value. While enabled, that flag drives an interrupt line. Software clears it with a write-one bit.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the prescaler reads 0, the reload register reads 0xFFF, the status and early-warning registers read 0, the counter is stopped, and `rst_req` and `ew_irq` are low.
- R2: Writing 0x5555 (the full 32-bit word) to the key register at byte address 0x00 unlocks writes. Unlocked writes to the prescaler (0x04, bits [3:0]), the reload register (0x08, bits [11:0]) and the early-warning register (0x14, enable bit 15, compare bits [11:0]) are stored and read back at once. The key register reads 0.
- R3: Any other key word relocks the block, including 0xAAAA and 0xCCCC. A write to a protected register while locked changes neither its readback nor the status register.
- R4: The status register at 0x0C has these busy flags: bit 0 for the prescaler, bit 1 for the reload value and bit 3 for the early-warning control. Each is set by an accepted write and clears on the third slow tick after it. Only then does the written value take effect. Bit 2 always reads 0.
- R5: Key 0xCCCC starts counting and loads the counter from the applied reload value. No key value stops a started counter.
- R6: Prescaler codes 0 to 6 make one counter step every 4, 8, 16, 32, 64, 128 or 256 slow ticks. Codes above 6 divide by 256.
- R7: A step taken while the counter is zero raises `rst_req` for exactly one clock cycle and reloads the counter. A full period is (reload+1) x divider slow ticks.
- R8: Key 0xAAAA reloads the counter and restarts the prescaler count, so the next expiry comes one full period later.
- R9: A step taken while the counter equals the early-warning compare value sets the warning flag. `ew_irq` is the flag gated by the applied enable bit. An unlocked write with bit 14 set to 0x14 clears the flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | One-cycle enable standing for an edge of the slow clock |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
Each result has its own due cycle:
- Readback and the store of a written value are due in the cycle after the write edge, and the bench reads them at the following falling edge.
- A busy flag drops in the cycle after the clock edge that samples the third slow tick.
- `rst_req` and the warning flag change in the cycle after the edge that samples the enabling tick.

The bench holds each tick high for one cycle and samples on the falling edge that ends it. This lets it count the exact tick index of every reset pulse and interrupt rise, and compare that index with the period worked out from the reload value and divider.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // register byte offsets
  localparam int unsigned OFF_KEY  = 32'h00;
  localparam int unsigned OFF_PRE  = 32'h04;
  localparam int unsigned OFF_RLD  = 32'h08;
  localparam int unsigned OFF_STAT = 32'h0C;
  localparam int unsigned OFF_EW   = 32'h14;

  // key words
  localparam logic [31:0] KEY_UNLOCK  = 32'h0000_5555;
  localparam logic [31:0] KEY_REFRESH = 32'h0000_AAAA;
  localparam logic [31:0] KEY_START   = 32'h0000_CCCC;

  // early-warning control fields
  localparam int unsigned EW_EN_BIT  = 15;
  localparam int unsigned EW_CLR_BIT = 14;

  typedef struct packed {
    logic ew_busy;
    logic win_busy;
    logic rld_busy;
    logic pre_busy;
  } stat_t;
endpackage

// File: rtl/kwdt_keyctl.sv
module kwdt_keyctl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              unlocked,
  output logic              started,
  output logic              start_p,
  output logic              refresh_p
);
  logic unlocked_d, started_d;

  assign start_p   = key_wr && (key_val == DATA_W'(kwdt_pkg::KEY_START));
  assign refresh_p = key_wr && (key_val == DATA_W'(kwdt_pkg::KEY_REFRESH));

  always_comb begin
    unlocked_d = unlocked;
    started_d  = started;
    if (key_wr) unlocked_d = (key_val == DATA_W'(kwdt_pkg::KEY_UNLOCK));
    if (start_p) started_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      started  <= 1'b0;
    end else begin
      unlocked <= unlocked_d;
      started  <= started_d;
    end
  end

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val != DATA_W'(kwdt_pkg::KEY_UNLOCK)) |=> !unlocked);

  // R5
  no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> started);
endmodule

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
  parameter int unsigned W       = 12,
  parameter int unsigned TICKS   = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         tick,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  shadow_d, active_d;

  assign pending = (cnt_q != '0);

  always_comb begin
    cnt_d    = cnt_q;
    shadow_d = shadow;
    active_d = active;
    if (wr) begin
      shadow_d = wval;
      cnt_d    = CW'(TICKS);
    end else if (tick && pending) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) active_d = shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shadow <= RST_VAL;
      active <= RST_VAL;
    end else begin
      cnt_q  <= cnt_d;
      shadow <= shadow_d;
      active <= active_d;
    end
  end

  // R4
  busy_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> pending);

  // R4
  busy_clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(tick));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int unsigned PRE_W      = 4,
  parameter int unsigned MAX_CODE   = 6,
  parameter int unsigned BASE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [PRE_W-1:0] code,
  output logic             step
);
  localparam int unsigned DW = BASE_SHIFT + MAX_CODE;

  logic [DW-1:0]    pcnt_q, pcnt_d, div_m1;
  logic [DW:0]      div_full;
  logic [PRE_W-1:0] code_eff;
  int unsigned      sh;

  always_comb begin
    code_eff = (code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : code;
    sh       = 32'(code_eff) + BASE_SHIFT;
    div_full = (DW+1)'(1) << sh;
    div_m1   = DW'(div_full - 1'b1);
  end

  assign step = run && tick && !clear && (pcnt_q >= div_m1);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clear || !run)  pcnt_d = '0;
    else if (step)      pcnt_d = '0;
    else if (tick)      pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R6
  restart_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pcnt_q == '0));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             step,
  input  logic [CNT_W-1:0] ew_cmp,
  input  logic             ew_clr,
  output logic             rst_req,
  output logic             ew_flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_d, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    req_d  = 1'b0;
    flag_d = ew_flag;
    if (load) begin
      cnt_d = reload_val;
    end else if (run && step) begin
      if (cnt_q == '0) begin
        cnt_d = reload_val;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      if (cnt_q == ew_cmp) flag_d = 1'b1;
    end
    if (ew_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      rst_req <= 1'b0;
      ew_flag <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_req <= req_d;
      ew_flag <= flag_d;
    end
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7
  reload_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == $past(reload_val)));

  // R9
  ew_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ew_clr |=> !ew_flag);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned PRE_W      = 4,
  parameter int unsigned SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              ew_irq
);
  import kwdt_pkg::*;

  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(OFF_PRE);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFF_RLD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EW   = ADDR_W'(OFF_EW);
  localparam int unsigned EW_W = CNT_W + 1;

  // reset: asserted asynchronously, released on clk
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic unlocked, started, start_p, refresh_p;
  logic key_wr, wr_pre, wr_rld, wr_ew, ew_clr;

  assign key_wr = bus_we && (bus_addr == A_KEY);
  assign wr_pre = bus_we && unlocked && (bus_addr == A_PRE);
  assign wr_rld = bus_we && unlocked && (bus_addr == A_RLD);
  assign wr_ew  = bus_we && unlocked && (bus_addr == A_EW);
  assign ew_clr = wr_ew && bus_wdata[EW_CLR_BIT];

  kwdt_keyctl #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_s), .key_wr(key_wr), .key_val(bus_wdata),
    .unlocked(unlocked), .started(started),
    .start_p(start_p), .refresh_p(refresh_p)
  );

  logic [PRE_W-1:0] pre_shadow, pre_active;
  logic [CNT_W-1:0] rld_shadow, rld_active;
  logic [EW_W-1:0]  ew_shadow, ew_active, ew_wval;
  stat_t            stat;

  assign ew_wval = {bus_wdata[EW_EN_BIT], bus_wdata[CNT_W-1:0]};

  kwdt_sync #(.W(PRE_W), .TICKS(SYNC_TICKS), .RST_VAL('0)) u_pre_sync (
    .clk(clk), .rst_n(rst_s), .wr(wr_pre), .wval(bus_wdata[PRE_W-1:0]),
    .tick(slow_tick), .shadow(pre_shadow), .active(pre_active),
    .pending(stat.pre_busy)
  );

  kwdt_sync #(.W(CNT_W), .TICKS(SYNC_TICKS), .RST_VAL('1)) u_rld_sync (
    .clk(clk), .rst_n(rst_s), .wr(wr_rld), .wval(bus_wdata[CNT_W-1:0]),
    .tick(slow_tick), .shadow(rld_shadow), .active(rld_active),
    .pending(stat.rld_busy)
  );

  kwdt_sync #(.W(EW_W), .TICKS(SYNC_TICKS), .RST_VAL('0)) u_ew_sync (
    .clk(clk), .rst_n(rst_s), .wr(wr_ew), .wval(ew_wval),
    .tick(slow_tick), .shadow(ew_shadow), .active(ew_active),
    .pending(stat.ew_busy)
  );

  assign stat.win_busy = 1'b0;

  logic step, ew_flag, cnt_load;
  assign cnt_load = start_p || refresh_p;

  kwdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .run(started), .clear(cnt_load),
    .tick(slow_tick), .code(pre_active), .step(step)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .run(started), .load(cnt_load),
    .reload_val(rld_active), .step(step), .ew_cmp(ew_active[CNT_W-1:0]),
    .ew_clr(ew_clr), .rst_req(rst_req), .ew_flag(ew_flag)
  );

  assign ew_irq = ew_flag && ew_active[CNT_W];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PRE:  bus_rdata = DATA_W'(pre_shadow);
      A_RLD:  bus_rdata = DATA_W'(rld_shadow);
      A_STAT: bus_rdata = DATA_W'(stat);
      A_EW: begin
        bus_rdata[EW_EN_BIT]   = ew_shadow[CNT_W];
        bus_rdata[CNT_W-1:0]   = ew_shadow[CNT_W-1:0];
      end
      default: bus_rdata = '0;
    endcase
  end

  // R3
  locked_reload_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_we && bus_addr == A_RLD && !unlocked) |=> $stable(rld_shadow));
endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, slow_tick, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rst_req, ew_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .ew_irq(ew_irq)
  );

  typedef struct packed {
    logic [31:0] key;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic [3:0]  exp_st;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h5555, 5'h08, 32'h0000_0123, 32'h0000_0123, 4'h2},
    '{32'h1234, 5'h08, 32'h0000_0456, 32'h0000_0123, 4'h0},
    '{32'h5555, 5'h04, 32'h0000_0005, 32'h0000_0005, 4'h1},
    '{32'hAAAA, 5'h04, 32'h0000_0002, 32'h0000_0005, 4'h0},
    '{32'h5555, 5'h14, 32'h0000_8007, 32'h0000_8007, 4'h8},
    '{32'h5556, 5'h14, 32'h0000_0000, 32'h0000_8007, 4'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; slow_tick = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n, output int pulses, output int first);
    pulses = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk) slow_tick = 1'b1;
      @(negedge clk) slow_tick = 1'b0;
      if (rst_req) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
  endtask

  // setup helper: unlock, program prescaler and reload, let them apply
  task automatic setup(input logic [3:0] code, input logic [11:0] rld);
    int p, f;
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'(code));
    wr(5'h08, 32'(rld));
    ticks(3, p, f);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p, f;
    int codes [4];
    int exps  [4];
    codes = '{0, 2, 6, 9};
    exps  = '{4, 16, 256, 256};

    // R1 reset state
    do_reset();
    rd(5'h04, d); chk("R1 prescaler", d, 32'h0);
    rd(5'h08, d); chk("R1 reload", d, 32'hFFF);
    rd(5'h0C, d); chk("R1 status", d, 32'h0);
    rd(5'h14, d); chk("R1 ew", d, 32'h0);
    rd(5'h00, d); chk("R2 key reads 0", d, 32'h0);
    chk("R1 rst_req", 32'(rst_req), 32'h0);
    chk("R1 ew_irq", 32'(ew_irq), 32'h0);
    ticks(20, p, f); chk("R1 stopped, no pulse", 32'(p), 32'h0);

    // R2 / R3 protection table
    foreach (VEC[i]) begin
      wr(5'h00, VEC[i].key);
      wr(VEC[i].addr, VEC[i].data);
      rd(5'h0C, d);
      chk(VEC[i].exp_st != 0 ? "R2 status" : "R3 status", d, 32'(VEC[i].exp_st));
      rd(VEC[i].addr, d);
      chk(VEC[i].exp_st != 0 ? "R2 readback" : "R3 readback", d, VEC[i].exp_rd);
      ticks(3, p, f);
    end

    // R4 busy flags
    do_reset();
    wr(5'h00, 32'h5555);
    wr(5'h08, 32'h3);
    rd(5'h0C, d); chk("R4 busy set", d, 32'h2);
    ticks(2, p, f);
    rd(5'h0C, d); chk("R4 busy after 2 ticks", d, 32'h2);
    ticks(1, p, f);
    rd(5'h0C, d); chk("R4 busy cleared", d, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h14, 32'h0);
    rd(5'h0C, d); chk("R4 pre+ew busy, bit2 zero", d, 32'h9);
    ticks(3, p, f);

    // R5 / R7 expiry and no stop
    wr(5'h00, 32'hCCCC);
    ticks(16, p, f);
    chk("R7 first expiry tick", 32'(f), 32'd16);
    chk("R7 one pulse", 32'(p), 32'd1);
    ticks(16, p, f);
    chk("R7 second period", 32'(f), 32'd16);
    wr(5'h00, 32'h1111);
    wr(5'h00, 32'h0000);
    ticks(16, p, f);
    chk("R5 still counting after other keys", 32'(p), 32'd1);

    // R8 refresh
    do_reset();
    setup(4'd0, 12'd3);
    wr(5'h00, 32'hCCCC);
    ticks(10, p, f); chk("R8 no pulse before refresh", 32'(p), 32'd0);
    wr(5'h00, 32'hAAAA);
    ticks(15, p, f); chk("R8 pulse deferred", 32'(p), 32'd0);
    ticks(1, p, f);  chk("R8 pulse after full period", 32'(p), 32'd1);

    // R6 prescaler codes
    for (int k = 0; k < 4; k++) begin
      do_reset();
      setup(codes[k][3:0], 12'd0);
      wr(5'h00, 32'hCCCC);
      ticks(exps[k], p, f);
      chk("R6 divider period", 32'(f), 32'(exps[k]));
    end

    // R9 early warning
    do_reset();
    wr(5'h00, 32'h5555);
    wr(5'h08, 32'h3);
    wr(5'h14, 32'h8001);
    ticks(3, p, f);
    wr(5'h00, 32'hCCCC);
    ticks(11, p, f);
    chk("R9 irq low before compare", 32'(ew_irq), 32'h0);
    ticks(1, p, f);
    chk("R9 irq on compare step", 32'(ew_irq), 32'h1);
    wr(5'h14, 32'hC001);
    chk("R3 locked clear ignored", 32'(ew_irq), 32'h1);
    wr(5'h00, 32'h5555);
    wr(5'h14, 32'hC001);
    chk("R9 irq cleared", 32'(ew_irq), 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule